// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master driven through a small 32-bit register bus. Software selects one of two operating states in a master control register: a configuration state, in which the clock divider, word length, clock polarity, clock phase and bit order may be changed, and an active state, in which queued words are shifted out on the serial lines. Every word written to the data port becomes one full-duplex frame of 8 or 16 bits. The word received during that frame is read back from the same data port, oldest first.

Both directions are buffered by four-entry FIFOs. The receive side raises an interrupt once its fill level reaches a programmed threshold of one to four words. The transmit side raises an interrupt while its fill level is at or below a second threshold. A buffer-clear command empties both FIFOs and clears the sticky overrun flag. A stop request holds back new frames without leaving the active state. Chip selects are produced outside the block.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the registers read as follows: master control 0x0000_0040 (configuration state), control0 0x0000_0000, control1 0x0000_0108 (divider 1, 8-bit words) and status 0x0000_8006. `irq`, `sck` and `mosi` are all 0.
- R2: The divider and word length (control1 at 0x08, divider in bits [15:8], word length in bits [4:0]) and the polarity, phase and bit-order bits (control0 bits 0, 1 and 2) are written only while master control bits [7:6] equal 01. Outside that state, writes to them are ignored. The interrupt enables (control0 bit 8 for transmit, bit 9 for receive), the transmit threshold (bits [15:14]) and the receive threshold minus one (bits [13:12]) are writable in any state.
- R3: Frames are shifted only while master control bits [7:6] equal 10. In any other state, words written to the data port (0x18) wait in the transmit FIFO and `sck` does not toggle.
- R4: When control1 bits [4:0] equal 16, a frame carries 16 bits. Otherwise it carries the low 8 bits of the data word. Bits go most significant first unless control0 bit 2 is set, in which case they go least significant first.
- R5: While no frame is running, `sck` rests at control0 bit 0. When control0 bit 1 is 0, `mosi` is valid for capture at the first edge of each bit and the block captures `miso` there. When bit 1 is 1, capture happens at the second edge of each bit.
- R6: Each bit of a frame lasts n+1 clock cycles, where n is the divider in control1 bits [15:8], so that `sck` runs at the clock rate divided by (n+1).
- R7: Each frame stores the word received on `miso` into the receive FIFO. Reads of the data port return the stored words in arrival order, zero-extended, and each read removes one word. An 8-bit frame reads back with bits [15:8] equal to 0.
- R8: The transmit FIFO holds four words. A data-port write while it is full is dropped, and the status register reports the transmit fill count in bits [13:11] and transmit-not-full in bit 1.
- R9: A frame that completes while the receive FIFO holds four words is discarded and sets the overrun bit (status bit 7). The bit stays set until a master control write with bit 0 set. That write also empties both FIFOs. The status register reports the receive fill count in bits [10:8] and receive-not-empty in bit 0.
- R10: Status bit 14 is 1 while the receive fill count exceeds control0 bits [13:12]. `irq` is high while that bit and the receive enable (control0 bit 9) are both 1. Clearing the enable drops the request.
- R11: Status bit 15 is 1 while the transmit fill count is at or below control0 bits [15:14]. `irq` is also high while that bit and the transmit enable (control0 bit 8) are both 1.
- R12: Status bit 2 is 1 only when the transmit FIFO is empty and no frame is in progress.
- R13: Leaving the active state aborts a frame in progress. No word is stored for it, `sck` returns to its rest level and the shifter reports idle.
- R14: While master control bit 1 is set, no new frame starts, even in the active state. Clearing the bit lets the queued word go out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock for the block and for the serial clock divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; a data-port read removes one received word |
| bus_addr | input | AW (5) | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| irq | output | 1 | Level interrupt request from the receive and transmit level flags |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench loops `mosi` back to `miso`, so every frame's wire content and its read-back word can be predicted from the data written. A monitor rebuilds each word from `mosi` on the edge the selected phase makes the capture edge. A design with swapped phase, reversed bit order or a stuck high byte would therefore produce a word that does not match the queued expectation. The bench then probes the edges of the block's behaviour. A fifth write into a full transmit FIFO must not appear as an extra frame. A fifth received frame must set overrun without displacing the oldest word. Configuration writes in the active state must leave control1 unchanged. The receive interrupt must wait for exactly the fourth word at the highest threshold. A stop request must hold a queued word back, and an abort in the middle of a frame must return `sck` to rest and store nothing. A design that got any of these wrong would show an unexpected frame, a wrong fill count or overrun flag, an early or missing interrupt, or a partial word in the receive FIFO.

// File: rtl/spim_pkg.sv
package spim_pkg;
   // register byte offsets
   localparam logic [4:0] OFF_MCTL = 5'h00;
   localparam logic [4:0] OFF_CTL0 = 5'h04;
   localparam logic [4:0] OFF_CTL1 = 5'h08;
   localparam logic [4:0] OFF_STAT = 5'h14;
   localparam logic [4:0] OFF_DATA = 5'h18;

   // operating state encoding in master control [7:6]
   localparam logic [1:0] OPM_CFG = 2'b01;
   localparam logic [1:0] OPM_RUN = 2'b10;

   // word length code selecting the wide frame
   localparam logic [4:0] WLEN_WIDE = 5'd16;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + PW'(1);
         assign rp_nx = rp + PW'(1);
      end else begin : g_wrap
         assign wp_nx = (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
         assign rp_nx = (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign count = cnt;
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int DW    = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic [DW-1:0]    tx_word,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             lsb_first,
   input  logic             wide,
   input  logic [DIV_W-1:0] div,
   input  logic             miso,
   output logic             take,
   output logic             done,
   output logic [DW-1:0]    rx_word,
   output logic             busy,
   output logic             sck,
   output logic             mosi
);
   localparam int IW = $clog2(DW);

   logic [DIV_W-1:0] cnt, n_eff, half;
   logic [DIV_W:0]   span;
   logic [IW-1:0]    idx, last_idx, pos_cur, pos_nxt, pos_first;
   logic [DW-1:0]    sh, rx_r;

   assign n_eff     = (div == '0) ? DIV_W'(1) : div;
   assign span      = {1'b0, n_eff} + (DIV_W+1)'(1);
   assign half      = span[DIV_W:1];
   assign last_idx  = wide ? IW'(DW-1) : IW'(DW/2-1);
   assign pos_cur   = lsb_first ? idx : last_idx - idx;
   assign pos_nxt   = lsb_first ? idx + IW'(1) : last_idx - idx - IW'(1);
   assign pos_first = lsb_first ? '0 : last_idx;
   assign take      = en & ~busy & start;
   assign rx_word   = rx_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         idx  <= '0;
         sh   <= '0;
         rx_r <= '0;
         sck  <= 1'b0;
         mosi <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            busy <= 1'b0;
            sck  <= cpol;
         end else if (!busy) begin
            sck <= cpol;
            if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
               idx  <= '0;
               sh   <= tx_word;
               rx_r <= '0;
               mosi <= tx_word[pos_first];
            end
         end else begin
            // first edge of the bit
            if (cnt == '0) begin
               sck <= ~cpol;
               if (cpha) mosi <= sh[pos_cur];
               else      rx_r[pos_cur] <= miso;
            end
            // second edge of the bit
            if (cnt == half) begin
               sck <= cpol;
               if (cpha)                 rx_r[pos_cur] <= miso;
               else if (idx != last_idx) mosi <= sh[pos_nxt];
            end
            if (cnt == n_eff) begin
               cnt <= '0;
               if (idx == last_idx) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx <= idx + IW'(1);
               end
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
   parameter int FIFO_DEPTH = 4,
   parameter int DATA_W     = 16,
   parameter int DIV_W      = 8,
   parameter int AW         = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          irq,
   output logic          sck,
   output logic          mosi,
   input  logic          miso
);
   import spim_pkg::*;

   localparam int CW = $clog2(FIFO_DEPTH+1);

   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 7) begin : g_bad_depth
         $error("FIFO_DEPTH must lie in 2..7 to fit the 3-bit fill fields");
      end
      if (DATA_W != 16) begin : g_bad_width
         $error("DATA_W must be 16 (8- and 16-bit frames)");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
      if (AW < 5) begin : g_bad_aw
         $error("AW must cover offset 0x18");
      end
   endgenerate

   logic [1:0]       mode;
   logic             stop;
   logic             cpol, cpha, lsb_first, txie, rxie;
   logic [1:0]       rx_thr, tx_thr;
   logic [DIV_W-1:0] div;
   logic [4:0]       wlen;
   logic             ovr;

   logic wr_mctl, wr_ctl0, wr_ctl1, wr_data, rd_data;
   logic cfg_mode, run, clr;

   logic [DATA_W-1:0] tx_dout, rx_dout, rx_word;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              tx_pop, sh_done, busy, start;
   logic              tx_flag, rx_flag, idle;
   logic              unused_bits;

   assign wr_mctl  = bus_wr && (bus_addr[4:0] == OFF_MCTL);
   assign wr_ctl0  = bus_wr && (bus_addr[4:0] == OFF_CTL0);
   assign wr_ctl1  = bus_wr && (bus_addr[4:0] == OFF_CTL1);
   assign wr_data  = bus_wr && (bus_addr[4:0] == OFF_DATA);
   assign rd_data  = bus_rd && (bus_addr[4:0] == OFF_DATA);
   assign cfg_mode = (mode == OPM_CFG);
   assign run      = (mode == OPM_RUN);
   assign clr      = wr_mctl & bus_wdata[0];
   assign start    = run & ~stop & ~tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= OPM_CFG;
         stop      <= 1'b0;
         cpol      <= 1'b0;
         cpha      <= 1'b0;
         lsb_first <= 1'b0;
         txie      <= 1'b0;
         rxie      <= 1'b0;
         rx_thr    <= 2'd0;
         tx_thr    <= 2'd0;
         div       <= DIV_W'(1);
         wlen      <= 5'd8;
      end else begin
         if (wr_mctl) begin
            mode <= bus_wdata[7:6];
            stop <= bus_wdata[1];
         end
         if (wr_ctl0) begin
            tx_thr <= bus_wdata[15:14];
            rx_thr <= bus_wdata[13:12];
            rxie   <= bus_wdata[9];
            txie   <= bus_wdata[8];
            if (cfg_mode) begin
               lsb_first <= bus_wdata[2];
               cpha      <= bus_wdata[1];
               cpol      <= bus_wdata[0];
            end
         end
         if (wr_ctl1 && cfg_mode) begin
            div  <= bus_wdata[8 +: DIV_W];
            wlen <= bus_wdata[4:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovr <= 1'b0;
      else if (clr)              ovr <= 1'b0;
      else if (sh_done && rx_full) ovr <= 1'b1;
   end

   spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(wr_data), .din(bus_wdata[DATA_W-1:0]),
      .pop(tx_pop), .dout(tx_dout),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(sh_done), .din(rx_word),
      .pop(rd_data), .dout(rx_dout),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   spim_shift #(.DW(DATA_W), .DIV_W(DIV_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(run), .start(start),
      .tx_word(tx_dout), .cpol(cpol), .cpha(cpha),
      .lsb_first(lsb_first), .wide(wlen == WLEN_WIDE), .div(div),
      .miso(miso), .take(tx_pop), .done(sh_done), .rx_word(rx_word),
      .busy(busy), .sck(sck), .mosi(mosi)
   );

   assign tx_flag = (tx_cnt <= CW'(tx_thr));
   assign rx_flag = (rx_cnt >  CW'(rx_thr));
   assign idle    = tx_empty & ~busy;
   assign irq     = (rx_flag & rxie) | (tx_flag & txie);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr[4:0])
         OFF_MCTL: bus_rdata = {24'h0, mode, 4'h0, stop, 1'b0};
         OFF_CTL0: bus_rdata = {16'h0, tx_thr, rx_thr, 2'b00, rxie, txie,
                                5'h0, lsb_first, cpha, cpol};
         OFF_CTL1: bus_rdata = {16'h0, 8'(div), 3'b000, wlen};
         OFF_STAT: bus_rdata = {16'h0, tx_flag, rx_flag, 3'(tx_cnt), 3'(rx_cnt),
                                ovr, 4'h0, idle, ~tx_full, ~rx_empty};
         OFF_DATA: bus_rdata = rx_empty ? 32'h0 : {16'h0, rx_dout};
         default:  bus_rdata = '0;
      endcase
   end

   assign unused_bits = ^{bus_wdata[31:16], bus_wdata[11:10], bus_wdata[7:5],
                          bus_addr};
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_W      = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           run,
   input logic                           cfg_mode,
   input logic                           stop,
   input logic                           cpol,
   input logic                           sck,
   input logic [DIV_W-1:0]               div,
   input logic [4:0]                     wlen,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] tx_cnt,
   input logic                           tx_full,
   input logic                           tx_pop,
   input logic                           clr,
   input logic                           ovr,
   input logic                           idle,
   input logic                           busy
);
   localparam int CW = $clog2(FIFO_DEPTH+1);

   // R2: frame setup is frozen outside the configuration state
   p_cfg_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> ($stable(div) && $stable(wlen) && $stable(cpol)));

   // R13: outside the active state the clock settles to its rest level
   p_sck_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sck == $past(cpol)));

   // R8: a full transmit FIFO stays full until drained or cleared
   p_tx_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !tx_pop && !clr) |=> (tx_cnt == CW'(FIFO_DEPTH)));

   // R9: overrun is sticky until a buffer clear
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr) |=> ovr);

   // R12: idle status never coexists with a running frame
   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !busy);

   // R14: a stop request keeps an idle shifter idle
   p_stop_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !busy) |=> !busy);
endmodule

bind spim_ctrl spim_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .cfg_mode(cfg_mode), .stop(stop),
   .cpol(cpol), .sck(sck), .div(div), .wlen(wlen), .tx_cnt(tx_cnt),
   .tx_full(tx_full), .tx_pop(tx_pop), .clr(clr), .ovr(ovr),
   .idle(idle), .busy(busy)
);

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
module spim_ctrl_tb_top;
   localparam logic [4:0] A_MCTL = 5'h00, A_CTL0 = 5'h04, A_CTL1 = 5'h08,
                          A_STAT = 5'h14, A_DATA = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sck, mosi;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done_run = 0;

   // shadow of the frame setup the bench programmed
   bit s_cpol = 0, s_cpha = 0, s_lsb = 0, s_wide = 0;
   int s_n = 1;
   bit mon_en = 0;
   logic [15:0] exp_q [$];

   spim_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(mosi)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_frame(input logic [31:0] w);
      exp_q.push_back(s_wide ? w[15:0] : {8'h00, w[7:0]});
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] e);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, e);
   endtask

   task automatic wait_idle;
      logic [31:0] d;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STAT, d);
         if (d[2]) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic summary;
      if (!done_run) begin
         done_run = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: rebuild each frame from mosi on the capture edge (scoreboard)
   bit prv = 0;
   int m_bits = 0, last_lead = 0;
   logic [15:0] m_word = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mon_en) begin
            m_bits = 0;
            m_word = '0;
         end else if (sck !== prv) begin
            automatic bit lead = (prv == s_cpol);
            automatic int w = s_wide ? 16 : 8;
            if (lead) begin
               if (m_bits > 0) chk("R6 bit period", cyc - last_lead, s_n + 1);
               last_lead = cyc;
            end
            if (lead ^ s_cpha) begin
               m_word[s_lsb ? m_bits : w - 1 - m_bits] = mosi;
               m_bits++;
               if (m_bits == w) begin
                  if (exp_q.size() == 0) chk("R3/R8 unexpected frame", {16'h0, m_word}, 32'hxxxx_dead);
                  else                   chk("R4 frame on mosi", {16'h0, m_word}, {16'h0, exp_q.pop_front()});
                  m_bits = 0;
                  m_word = '0;
               end
            end
         end
         prv = sck;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 mctl", A_MCTL, 32'h40);
      rd_chk("R1 ctl0", A_CTL0, 32'h0);
      rd_chk("R1 ctl1", A_CTL1, 32'h0108);
      rd_chk("R1 stat", A_STAT, 32'h8006);
      chk("R1 irq/sck/mosi", {irq, sck, mosi}, 3'b000);

      // 8-bit MSB-first, mode 0, divider 1
      mon_en = 1;
      wr(A_MCTL, 32'h80);
      expect_frame(32'hC3A5);
      wr(A_DATA, 32'hC3A5);
      wait_idle();
      rd_chk("R7 8-bit readback", A_DATA, 32'h00A5);

      // 16-bit LSB-first, cpol=1 cpha=1, divider 3
      mon_en = 0;
      wr(A_MCTL, 32'h41);
      wr(A_CTL1, 32'h0310);
      wr(A_CTL0, 32'h0007);
      s_cpol = 1; s_cpha = 1; s_lsb = 1; s_wide = 1; s_n = 3;
      repeat (2) @(negedge clk);
      chk("R5 rest level", {31'h0, sck}, 32'h1);
      mon_en = 1;
      wr(A_MCTL, 32'h80);
      expect_frame(32'h1234);
      expect_frame(32'hBEEF);
      wr(A_DATA, 32'h1234);
      wr(A_DATA, 32'hBEEF);
      wait_idle();
      rd_chk("R7 order first", A_DATA, 32'h1234);
      rd_chk("R7 order second", A_DATA, 32'hBEEF);

      // R2 configuration lock in active state
      wr(A_CTL1, 32'h0508);
      rd_chk("R2 ctl1 locked", A_CTL1, 32'h0310);
      wr(A_CTL0, 32'h3200);
      rd_chk("R2 ctl0 partial", A_CTL0, 32'h3207);

      // R10 receive threshold 4
      expect_frame(32'h0001);
      wr(A_DATA, 32'h0001);
      wait_idle();
      chk("R10 below level irq", {31'h0, irq}, 32'h0);
      for (int k = 2; k <= 4; k++) begin
         expect_frame(k);
         wr(A_DATA, k);
      end
      wait_idle();
      chk("R10 at level irq", {31'h0, irq}, 32'h1);
      rd(A_STAT, d);
      chk("R10 flag and count", {29'h0, d[14], d[9:8]}, {29'h0, 1'b1, 2'b00});
      chk("R7 rx count 4", {29'h0, d[10:8]}, 32'h4);
      wr(A_CTL0, 32'h3000);
      chk("R10 enable off", {31'h0, irq}, 32'h0);
      for (int k = 1; k <= 4; k++) rd_chk("R7 fifo order", A_DATA, k);
      wr(A_CTL0, 32'h0200);
      expect_frame(32'h0055);
      wr(A_DATA, 32'h0055);
      wait_idle();
      chk("R10 level 1 irq", {31'h0, irq}, 32'h1);
      rd_chk("R7 single", A_DATA, 32'h0055);
      chk("R10 drained irq", {31'h0, irq}, 32'h0);
      wr(A_CTL0, 32'h0000);

      // R9 overrun
      for (int k = 1; k <= 5; k++) begin
         expect_frame(k * 32'h11);
         wr(A_DATA, k * 32'h11);
         wait_idle();
      end
      rd(A_STAT, d);
      chk("R9 overrun set", {31'h0, d[7]}, 32'h1);
      chk("R9 rx count full", {29'h0, d[10:8]}, 32'h4);
      rd_chk("R9 oldest kept", A_DATA, 32'h11);
      wr(A_MCTL, 32'h81);
      rd(A_STAT, d);
      chk("R9 clear overrun", {31'h0, d[7]}, 32'h0);
      chk("R9 clear rx", {29'h0, d[10:8]}, 32'h0);

      // R8 / R3 full transmit FIFO in configuration state
      wr(A_MCTL, 32'h40);
      for (int k = 1; k <= 5; k++) wr(A_DATA, 32'hA000 + k);
      rd(A_STAT, d);
      chk("R8 tx count", {29'h0, d[13:11]}, 32'h4);
      chk("R8 not-full bit", {31'h0, d[1]}, 32'h0);
      chk("R12 idle with queued word", {31'h0, d[2]}, 32'h0);
      chk("R3 no shifting in config", {29'h0, d[10:8]}, 32'h0);
      chk("R3 sck at rest", {31'h0, sck}, 32'h1);
      for (int k = 1; k <= 4; k++) expect_frame(32'hA000 + k);
      wr(A_MCTL, 32'h80);
      wait_idle();
      for (int k = 1; k <= 4; k++) rd_chk("R8 kept words", A_DATA, 32'hA000 + k);
      rd(A_STAT, d);
      chk("R8 fifth dropped", {29'h0, d[10:8]}, 32'h0);

      // R11 transmit level flag
      wr(A_MCTL, 32'h40);
      wr(A_CTL0, 32'h8107);
      chk("R11 irq at empty", {31'h0, irq}, 32'h1);
      for (int k = 0; k < 3; k++) wr(A_DATA, k);
      rd(A_STAT, d);
      chk("R11 flag above level", {31'h0, d[15]}, 32'h0);
      chk("R11 irq above level", {31'h0, irq}, 32'h0);
      wr(A_MCTL, 32'h41);
      chk("R11 irq after clear", {31'h0, irq}, 32'h1);
      wr(A_CTL0, 32'h0007);
      chk("R11 enable off", {31'h0, irq}, 32'h0);

      // R14 stop request
      wr(A_MCTL, 32'h82);
      wr(A_DATA, 32'h5A5A);
      repeat (40) @(negedge clk);
      rd(A_STAT, d);
      chk("R14 held tx", {29'h0, d[13:11]}, 32'h1);
      chk("R14 no rx", {29'h0, d[10:8]}, 32'h0);
      expect_frame(32'h5A5A);
      wr(A_MCTL, 32'h80);
      wait_idle();
      rd_chk("R14 released word", A_DATA, 32'h5A5A);

      // R13 abort mid-frame
      mon_en = 0;
      wr(A_MCTL, 32'h40);
      wr(A_CTL1, 32'h1410);
      wr(A_MCTL, 32'h80);
      wr(A_DATA, 32'hFFFF);
      repeat (60) @(negedge clk);
      rd(A_STAT, d);
      chk("R12 busy not idle", {31'h0, d[2]}, 32'h0);
      wr(A_MCTL, 32'h41);
      repeat (2) @(negedge clk);
      chk("R13 sck rest", {31'h0, sck}, 32'h1);
      rd(A_STAT, d);
      chk("R13 idle after abort", {31'h0, d[2]}, 32'h1);
      repeat (400) @(negedge clk);
      rd(A_STAT, d);
      chk("R13 nothing stored", {29'h0, d[10:8]}, 32'h0);

      chk("R3 all expected frames seen", exp_q.size(), 32'h0);
      summary();
   end
endmodule